// File: doc/BRIEF.md
# Stack Push/Pull Sequencer

This block moves values between a processor's registers and a byte-wide stack memory, one byte per clock. A register push or pull carries a 64-bit data word, a byte count from 1 to 8 and an operation code. The block drives the address, strobes and write data of the stack memory port and assembles pulled bytes into a result word. It also runs the fixed transfer sequences used for short and long subroutine call and return, software breakpoint and return from interrupt. At the end of each sequence it reports the new program counter and, where one applies, the restored status word.

The block owns the stack pointer and a 16-bit bank register that supplies the upper half of every stack address. Both can be loaded directly in a single cycle. The bank load covers the prefixed transfer-to-stack-pointer form, whose immediate operand sets the bank. The stack grows toward lower addresses. Multi-byte values are pushed most significant byte first, so they sit little-endian in memory. The stack memory is assumed to return read data in the same cycle as the address.

Top module: `stk_xfer_engine`

## Requirements
- R1: After a synchronous active-low reset, busy, done and both memory strobes are low, the stack pointer equals the parameter SP_INIT and the bank register is 0.
- R2: A register push (req_op 1) with count n writes the low n bytes of req_data, one per cycle. Each write goes to {bank, sp}, after which sp decrements. Byte n-1 is written first and byte 0 last, so byte 0 ends at the lowest address. Bytes above n are never written.
- R3: A register pull (req_op 2) with count n first increments sp and then reads {bank, sp} each cycle. The k-th byte read lands in bits 8k+7..8k of pull_data, the upper bits are zero, and pull_valid pulses with done.
- R4: An accepted request raises busy on the next cycle. Busy stays high for exactly as many cycles as bytes in the sequence. done pulses for one cycle in the first cycle with busy low.
- R5: A request is ignored, leaving sp, bank and memory untouched, when busy is high. It is also ignored when a push or pull count is 0 or above 8, or when req_op is 0 or above 10.
- R6: A short call (req_op 3) pushes the low 2 bytes of req_pc, then pulses pc_we with pc_val equal to req_target. A short return (req_op 4) pulls 2 bytes and pulses pc_we with pc_val equal to the pulled value, zero-extended.
- R7: A long call (req_op 5) pushes all 8 bytes of req_pc and redirects to req_target. A long return (req_op 6) pulls 8 bytes into pc_val.
- R8: A breakpoint (req_op 7) pushes the 8-byte req_status and then the 8-byte req_pc, 16 cycles in all. It then pulses pc_we with pc_val equal to req_target, the vector contents, and does not pulse st_we.
- R9: Return from interrupt (req_op 8) pulls 8 bytes into st_val first and 8 bytes into pc_val second. It pulses st_we and pc_we together with done.
- R10: req_op 9 loads sp from req_data[15:0] and req_op 10 loads bank from req_data[15:0]. Each takes effect on the next cycle without raising busy. The upper 16 address bits of every stack access equal bank.
- R11: The stack pointer wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when busy is low |
| req_op | input | 4 | Operation code |
| req_bytes | input | CNT_W (4) | Byte count for register push/pull |
| req_data | input | DATA_W (64) | Register value to push, or load value for sp/bank |
| req_pc | input | DATA_W (64) | Current program counter |
| req_status | input | DATA_W (64) | Current status word |
| req_target | input | DATA_W (64) | Call target or breakpoint vector contents |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pull_data | output | DATA_W (64) | Assembled register pull result |
| pull_valid | output | 1 | pull_data updated, with done |
| pc_we | output | 1 | Load program counter, with done |
| pc_val | output | DATA_W (64) | New program counter |
| st_we | output | 1 | Load status word, with done |
| st_val | output | DATA_W (64) | Restored status word |
| sp | output | PTR_W (16) | Stack pointer |
| bank | output | BANK_W (16) | Stack bank register |
| mem_addr | output | BANK_W+PTR_W (32) | Stack memory byte address |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the same cycle |

## Verification
The bench builds the block with a 64-bit data width and 16-bit pointer and bank registers. These are the widths at which long calls, breakpoints and interrupt returns move full 8-byte words, and where a 64K-byte array models the whole low address half. SP_INIT is overridden to 0x0040 so the reset value is told apart from an all-ones default. Wrap-around below address 0 is reached by loading sp with 1 and pushing four bytes. Together these settings reach every byte position of the 64-bit word, the 2-byte short return with its zero upper bits, and a nonzero bank on the address bus.

// File: rtl/stk_pkg.sv
// Shared types for the stack transfer engine.
// Assumes a byte count of at most 255 per sequence item.
package stk_pkg;

    localparam int LEN_W = 8;

    typedef enum logic [3:0] {
        OP_IDLE    = 4'd0,
        OP_PUSH    = 4'd1,
        OP_PULL    = 4'd2,
        OP_CALL    = 4'd3,
        OP_RET     = 4'd4,
        OP_LCALL   = 4'd5,
        OP_LRET    = 4'd6,
        OP_BRK     = 4'd7,
        OP_RTI     = 4'd8,
        OP_SETSP   = 4'd9,
        OP_SETBANK = 4'd10
    } stk_op_e;

    typedef enum logic [1:0] {
        SRC_REG  = 2'd0,
        SRC_PC   = 2'd1,
        SRC_STAT = 2'd2
    } stk_src_e;

    // One item of a sequence: direction, which word, how many bytes, final item or not.
    typedef struct packed {
        logic             is_push;
        stk_src_e         src;
        logic [LEN_W-1:0] len;
        logic             last;
    } stk_item_t;

endpackage

// File: rtl/stk_seq_ctrl.sv
// Sequence controller: accepts requests, walks the items of each sequence one
// byte per cycle and raises the completion strobes.
// Assumes sp/bank loads are single-cycle and handled by the pointer unit.
module stk_seq_ctrl
    import stk_pkg::*;
#(
    parameter int NBYTES         = 8,
    parameter int CNT_W          = 4,
    parameter int SHORT_PC_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_op,
    input  logic [CNT_W-1:0] req_bytes,
    output logic             busy,
    output logic             accept,
    output logic             set_sp_en,
    output logic             set_bank_en,
    output logic             byte_push,
    output logic             byte_pull,
    output stk_src_e         cur_src,
    output logic [LEN_W-1:0] cur_len,
    output logic [LEN_W-1:0] cur_k,
    output logic             last_byte,
    output logic             done,
    output logic             pc_we,
    output logic             st_we,
    output logic             pull_valid
);

    stk_op_e          op_in;
    stk_op_e          op_q;
    logic             busy_q;
    logic             step_q;
    logic             done_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] k_q;
    logic             count_ok;
    logic             seq_ok;
    stk_item_t        cur;

    // Describes item 'step' of the sequence for operation 'op'.
    function automatic stk_item_t item_of(stk_op_e op, logic step, logic [LEN_W-1:0] nreg);
        stk_item_t it;
        it = '{is_push: 1'b1, src: SRC_REG, len: nreg, last: 1'b1};
        case (op)
            OP_PUSH:  it.is_push = 1'b1;
            OP_PULL:  it.is_push = 1'b0;
            OP_CALL:  begin it.src = SRC_PC; it.len = LEN_W'(SHORT_PC_BYTES); end
            OP_RET:   begin it.is_push = 1'b0; it.src = SRC_PC; it.len = LEN_W'(SHORT_PC_BYTES); end
            OP_LCALL: begin it.src = SRC_PC; it.len = LEN_W'(NBYTES); end
            OP_LRET:  begin it.is_push = 1'b0; it.src = SRC_PC; it.len = LEN_W'(NBYTES); end
            OP_BRK: begin
                it.len  = LEN_W'(NBYTES);
                it.src  = step ? SRC_PC : SRC_STAT;
                it.last = step;
            end
            OP_RTI: begin
                it.is_push = 1'b0;
                it.len     = LEN_W'(NBYTES);
                it.src     = step ? SRC_PC : SRC_STAT;
                it.last    = step;
            end
            default: it.is_push = 1'b1;
        endcase
        return it;
    endfunction

    // Decodes the incoming request and decides whether it is taken.
    always_comb begin
        op_in    = stk_op_e'(req_op);
        count_ok = (req_bytes != '0) && (int'(req_bytes) <= NBYTES);
        case (op_in)
            OP_PUSH, OP_PULL:                    seq_ok = count_ok;
            OP_CALL, OP_RET, OP_LCALL, OP_LRET,
            OP_BRK, OP_RTI:                      seq_ok = 1'b1;
            default:                             seq_ok = 1'b0;
        endcase
        accept      = req_valid && !busy_q && seq_ok;
        set_sp_en   = req_valid && !busy_q && (op_in == OP_SETSP);
        set_bank_en = req_valid && !busy_q && (op_in == OP_SETBANK);
    end

    // Current item and per-byte strobes.
    always_comb begin
        cur       = item_of(op_q, step_q, len_q);
        cur_src   = cur.src;
        cur_len   = cur.len;
        cur_k     = k_q;
        last_byte = (k_q == cur.len - LEN_W'(1));
        byte_push = busy_q && cur.is_push;
        byte_pull = busy_q && !cur.is_push;
    end

    // Sequence state: operation, item step, byte index, busy and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            step_q <= 1'b0;
            op_q   <= OP_IDLE;
            len_q  <= '0;
            k_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                op_q   <= op_in;
                len_q  <= LEN_W'(req_bytes);
                step_q <= 1'b0;
                k_q    <= '0;
            end else if (busy_q) begin
                if (last_byte) begin
                    k_q <= '0;
                    if (cur.last) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        step_q <= 1'b1;
                    end
                end else begin
                    k_q <= k_q + LEN_W'(1);
                end
            end
        end
    end

    // Completion strobes, qualified by the finished operation.
    always_comb begin
        busy       = busy_q;
        done       = done_q;
        pull_valid = done_q && (op_q == OP_PULL);
        st_we      = done_q && (op_q == OP_RTI);
        pc_we      = done_q && (op_q inside {OP_CALL, OP_RET, OP_LCALL, OP_LRET, OP_BRK, OP_RTI});
    end

    // R4: done only directly after a busy cycle, with busy dropped.
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));

    // R4: the byte index never runs past the item length.
    a_r4_k_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (k_q < cur.len));

    // R4: busy cannot drop before the final byte of the final item.
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last_byte) |=> busy_q);

endmodule

// File: rtl/stk_ptr_unit.sv
// Stack pointer and bank register, and the stack memory address and strobes.
// Assumes push and pull strobes are never high together and that loads arrive
// only while no sequence runs.
module stk_ptr_unit #(
    parameter int          PTR_W   = 16,
    parameter int          BANK_W  = 16,
    parameter int unsigned SP_INIT = 32'h0000_FFFF,
    localparam int         ADDR_W  = BANK_W + PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              byte_push,
    input  logic              byte_pull,
    input  logic              set_sp_en,
    input  logic              set_bank_en,
    input  logic [PTR_W-1:0]  sp_load,
    input  logic [BANK_W-1:0] bank_load,
    output logic [PTR_W-1:0]  sp,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re
);

    logic [PTR_W-1:0]  sp_q;
    logic [BANK_W-1:0] bank_q;

    // Pointer: direct load, post-decrement on push, pre-increment on pull.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= PTR_W'(SP_INIT);
        end else if (set_sp_en) begin
            sp_q <= sp_load;
        end else if (byte_push) begin
            sp_q <= sp_q - PTR_W'(1);
        end else if (byte_pull) begin
            sp_q <= sp_q + PTR_W'(1);
        end
    end

    // Bank register: loaded only by its own request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (set_bank_en) begin
            bank_q <= bank_load;
        end
    end

    // Memory address and strobes for the byte moved this cycle.
    always_comb begin
        mem_addr = {bank_q, (byte_pull ? sp_q + PTR_W'(1) : sp_q)};
        mem_we   = byte_push;
        mem_re   = byte_pull;
        sp       = sp_q;
        bank     = bank_q;
    end

    // R2: every pushed byte moves the pointer down by one, modulo the width.
    a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        byte_push |=> (sp_q == $past(sp_q) - PTR_W'(1)));

    // R3: every pulled byte moves the pointer up by one, modulo the width.
    a_r3_pull_inc: assert property (@(posedge clk) disable iff (!rst_n)
        byte_pull |=> (sp_q == $past(sp_q) + PTR_W'(1)));

    // R2: the two memory strobes never overlap.
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R10: the bank cannot move while a sequence runs.
    a_r10_bank_steady: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bank_q));

endmodule

// File: rtl/stk_byte_path.sv
// Data path: captures the words of a request, selects the byte to write,
// and assembles pulled bytes into the register, program counter or status result.
// Assumes read data is valid in the cycle its address is driven.
module stk_byte_path
    import stk_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] req_pc,
    input  logic [DATA_W-1:0] req_status,
    input  logic [DATA_W-1:0] req_target,
    input  logic              byte_pull,
    input  stk_src_e          cur_src,
    input  logic [LEN_W-1:0]  cur_len,
    input  logic [LEN_W-1:0]  cur_k,
    input  logic              last_byte,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        mem_wdata,
    output logic [DATA_W-1:0] pull_data,
    output logic [DATA_W-1:0] pc_val,
    output logic [DATA_W-1:0] st_val
);

    logic [DATA_W-1:0] reg_q, pc_q, st_q;
    logic [DATA_W-1:0] acc_q, acc_next;
    logic [DATA_W-1:0] data_res, pc_res, st_res;
    logic [DATA_W-1:0] src_word;
    logic [LEN_W-1:0]  push_idx;

    // Push byte: highest requested byte first, lowest last.
    always_comb begin
        case (cur_src)
            SRC_PC:   src_word = pc_q;
            SRC_STAT: src_word = st_q;
            default:  src_word = reg_q;
        endcase
        push_idx  = cur_len - LEN_W'(1) - cur_k;
        mem_wdata = 8'(src_word >> {push_idx, 3'b000});
    end

    // Pull assembly: byte k goes to bit 8k, fresh zero word on the first byte.
    always_comb begin
        acc_next = ((cur_k == '0) ? '0 : acc_q) | (DATA_W'(mem_rdata) << {cur_k, 3'b000});
    end

    // Request capture at acceptance; the target is the default new program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
            pc_q  <= '0;
            st_q  <= '0;
        end else if (accept) begin
            reg_q <= req_data;
            pc_q  <= req_pc;
            st_q  <= req_status;
        end
    end

    // Pull accumulator and the three result words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            data_res <= '0;
            pc_res   <= '0;
            st_res   <= '0;
        end else begin
            if (accept) begin
                pc_res <= req_target;
            end else if (byte_pull) begin
                acc_q <= acc_next;
                if (last_byte) begin
                    case (cur_src)
                        SRC_PC:   pc_res   <= acc_next;
                        SRC_STAT: st_res   <= acc_next;
                        default:  data_res <= acc_next;
                    endcase
                end
            end
        end
    end

    assign pull_data = data_res;
    assign pc_val    = pc_res;
    assign st_val    = st_res;

    // R3: a finished register pull has nothing above its byte count.
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_pull && last_byte && cur_src == SRC_REG)
            |=> ((data_res >> {$past(cur_len), 3'b000}) == '0));

endmodule

// File: rtl/stk_xfer_engine.sv
// Top of the stack transfer engine: controller, pointer unit and data path.
// Assumes a byte-wide stack memory with same-cycle read data.
module stk_xfer_engine
    import stk_pkg::*;
#(
    parameter int          DATA_W         = 64,
    parameter int          PTR_W          = 16,
    parameter int          BANK_W         = 16,
    parameter int          SHORT_PC_BYTES = 2,
    parameter int unsigned SP_INIT        = 32'h0000_FFFF,
    localparam int         NBYTES         = DATA_W / 8,
    localparam int         CNT_W          = $clog2(NBYTES + 1),
    localparam int         ADDR_W         = BANK_W + PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] req_pc,
    input  logic [DATA_W-1:0] req_status,
    input  logic [DATA_W-1:0] req_target,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] pull_data,
    output logic              pull_valid,
    output logic              pc_we,
    output logic [DATA_W-1:0] pc_val,
    output logic              st_we,
    output logic [DATA_W-1:0] st_val,
    output logic [PTR_W-1:0]  sp,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    logic             accept, set_sp_en, set_bank_en;
    logic             byte_push, byte_pull, last_byte;
    stk_src_e         cur_src;
    logic [LEN_W-1:0] cur_len, cur_k;

    stk_seq_ctrl #(
        .NBYTES         (NBYTES),
        .CNT_W          (CNT_W),
        .SHORT_PC_BYTES (SHORT_PC_BYTES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_bytes   (req_bytes),
        .busy        (busy),
        .accept      (accept),
        .set_sp_en   (set_sp_en),
        .set_bank_en (set_bank_en),
        .byte_push   (byte_push),
        .byte_pull   (byte_pull),
        .cur_src     (cur_src),
        .cur_len     (cur_len),
        .cur_k       (cur_k),
        .last_byte   (last_byte),
        .done        (done),
        .pc_we       (pc_we),
        .st_we       (st_we),
        .pull_valid  (pull_valid)
    );

    stk_ptr_unit #(
        .PTR_W   (PTR_W),
        .BANK_W  (BANK_W),
        .SP_INIT (SP_INIT)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .byte_push   (byte_push),
        .byte_pull   (byte_pull),
        .set_sp_en   (set_sp_en),
        .set_bank_en (set_bank_en),
        .sp_load     (req_data[PTR_W-1:0]),
        .bank_load   (req_data[BANK_W-1:0]),
        .sp          (sp),
        .bank        (bank),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_re      (mem_re)
    );

    stk_byte_path #(
        .DATA_W (DATA_W)
    ) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_data   (req_data),
        .req_pc     (req_pc),
        .req_status (req_status),
        .req_target (req_target),
        .byte_pull  (byte_pull),
        .cur_src    (cur_src),
        .cur_len    (cur_len),
        .cur_k      (cur_k),
        .last_byte  (last_byte),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .pull_data  (pull_data),
        .pc_val     (pc_val),
        .st_val     (st_val)
    );

endmodule

// File: tb/sim_stk_xfer_engine.sv
`timescale 1ns/1ps
module sim_stk_xfer_engine;
    import stk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = 4'd0;
    logic [3:0]  req_bytes = 4'd0;
    logic [63:0] req_data = '0, req_pc = '0, req_status = '0, req_target = '0;
    logic        busy, done, pull_valid, pc_we, st_we, mem_we, mem_re;
    logic [63:0] pull_data, pc_val, st_val;
    logic [15:0] sp, bank;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    stk_xfer_engine #(.SP_INIT(32'h0000_0040)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bytes(req_bytes), .req_data(req_data), .req_pc(req_pc),
        .req_status(req_status), .req_target(req_target), .busy(busy), .done(done),
        .pull_data(pull_data), .pull_valid(pull_valid), .pc_we(pc_we), .pc_val(pc_val),
        .st_we(st_we), .st_val(st_val), .sp(sp), .bank(bank), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #2 clk = ~clk;

    // Stack memory model: same-cycle read, write on the clock edge.
    logic [7:0]  tmem [0:65535];
    logic [15:0] wr_hi = '0, rd_hi = '0;
    assign mem_rdata = tmem[mem_addr[15:0]];
    always @(posedge clk) begin
        if (mem_we) begin
            tmem[mem_addr[15:0]] <= mem_wdata;
            wr_hi <= mem_addr[31:16];
        end
        if (mem_re) rd_hi <= mem_addr[31:16];
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    // Captured at the done cycle of each request.
    int          got_busy;
    logic        got_done_next, got_pull_valid, got_pc_we, got_st_we;
    logic [63:0] got_pull_data, got_pc_val, got_st_val;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Issues one sequence request and checks its busy length and done pulse (R4).
    task automatic run_req(input logic [3:0] op, input logic [3:0] nb, input logic [63:0] d,
                           input logic [63:0] pc, input logic [63:0] st, input logic [63:0] tg,
                           input int exp_len, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bytes = nb;
        req_data = d; req_pc = pc; req_status = st; req_target = tg;
        @(negedge clk);
        req_valid = 1'b0;
        got_busy = 0;
        while (busy && got_busy < 100) begin
            got_busy++;
            @(negedge clk);
        end
        got_pull_valid = pull_valid; got_pc_we = pc_we; got_st_we = st_we;
        got_pull_data = pull_data; got_pc_val = pc_val; got_st_val = st_val;
        chk(got_busy == exp_len, {"R4 busy length ", tag}, 64'(got_busy), 64'(exp_len));
        chk(done == 1'b1, {"R4 done pulse ", tag}, 64'(done), 64'd1);
        @(negedge clk);
        chk(done == 1'b0, {"R4 done single ", tag}, 64'(done), 64'd0);
    endtask

    // Drives one single-cycle request and returns at the next sampling point.
    task automatic one_shot(input logic [3:0] op, input logic [3:0] nb, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bytes = nb; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(sp == 16'h0040, "R1 sp", 64'(sp), 64'h40);
        chk(bank == 16'h0000, "R1 bank", 64'(bank), 64'h0);
        chk(!mem_we && !mem_re, "R1 strobes", {62'd0, mem_we, mem_re}, 64'd0);
    endtask

    task automatic t_loads();
        one_shot(OP_SETSP, 4'd0, 64'hFFFF_0000_0000_0100);
        chk(sp == 16'h0100, "R10 sp load", 64'(sp), 64'h100);
        chk(busy == 1'b0, "R10 no busy", 64'(busy), 64'd0);
        one_shot(OP_SETBANK, 4'd0, 64'h0000_0000_0000_00A5);
        chk(bank == 16'h00A5, "R10 bank load", 64'(bank), 64'hA5);
    endtask

    task automatic t_push_pull();
        run_req(OP_PUSH, 4'd3, 64'h0000_0000_0011_2233, '0, '0, '0, 3, "push3");
        chk({tmem[16'h0100], tmem[16'h00FF], tmem[16'h00FE]} == 24'h112233, "R2 push3 bytes",
            64'({tmem[16'h0100], tmem[16'h00FF], tmem[16'h00FE]}), 64'h112233);
        chk(sp == 16'h00FD, "R2 push3 sp", 64'(sp), 64'hFD);
        chk(wr_hi == 16'h00A5, "R10 push bank half", 64'(wr_hi), 64'hA5);
        run_req(OP_PULL, 4'd3, '0, '0, '0, '0, 3, "pull3");
        chk(got_pull_valid && got_pull_data == 64'h112233, "R3 pull3 data", got_pull_data, 64'h112233);
        chk(sp == 16'h0100, "R3 pull3 sp", 64'(sp), 64'h100);
        chk(rd_hi == 16'h00A5, "R10 pull bank half", 64'(rd_hi), 64'hA5);
        run_req(OP_PUSH, 4'd5, 64'hDEAD_BEAA_BBCC_DDEE, '0, '0, '0, 5, "push5");
        chk(tmem[16'h00FB] != 8'hBE && tmem[16'h00FC] == 8'hEE, "R2 push5 low end",
            64'(tmem[16'h00FC]), 64'hEE);
        run_req(OP_PULL, 4'd5, '0, '0, '0, '0, 5, "pull5");
        chk(got_pull_data == 64'h0000_00AA_BBCC_DDEE, "R3 pull5 zero ext", got_pull_data, 64'hAABBCCDDEE);
        run_req(OP_PUSH, 4'd8, 64'h0123_4567_89AB_CDEF, '0, '0, '0, 8, "push8");
        chk(tmem[16'h0100] == 8'h01 && tmem[16'h00F9] == 8'hEF, "R2 push8 order",
            64'(tmem[16'h00F9]), 64'hEF);
        run_req(OP_PULL, 4'd8, '0, '0, '0, '0, 8, "pull8");
        chk(got_pull_data == 64'h0123_4567_89AB_CDEF, "R3 pull8 data", got_pull_data, 64'h0123456789ABCDEF);
    endtask

    task automatic t_ignored();
        logic [15:0] s0;
        s0 = sp;
        one_shot(OP_PUSH, 4'd0, 64'h77);
        chk(!busy && sp == s0, "R5 count zero", 64'(sp), 64'(s0));
        one_shot(OP_PULL, 4'd9, 64'h77);
        chk(!busy && sp == s0, "R5 count nine", 64'(sp), 64'(s0));
        one_shot(4'd15, 4'd2, 64'h77);
        chk(!busy && sp == s0 && bank == 16'h00A5, "R5 unused op", 64'(sp), 64'(s0));
        // Overlap: push 4, then try a pointer load and a push while busy.
        @(negedge clk);
        req_valid = 1'b1; req_op = OP_PUSH; req_bytes = 4'd4; req_data = 64'h0000_0000_CAFE_F00D;
        @(negedge clk);
        req_op = OP_SETSP; req_data = 64'h1234;
        @(negedge clk);
        req_op = OP_SETBANK; req_data = 64'h0033;
        @(negedge clk);
        req_op = OP_PUSH; req_bytes = 4'd2; req_data = 64'h9999;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(sp == s0 - 16'd4, "R5 busy ignores sp load", 64'(sp), 64'(s0 - 16'd4));
        chk(bank == 16'h00A5, "R5 busy ignores bank load", 64'(bank), 64'hA5);
        run_req(OP_PULL, 4'd4, '0, '0, '0, '0, 4, "pull after overlap");
        chk(got_pull_data == 64'hCAFE_F00D, "R5 stack holds only first push", got_pull_data, 64'hCAFEF00D);
    endtask

    task automatic t_calls();
        one_shot(OP_SETSP, 4'd0, 64'h0200);
        run_req(OP_CALL, 4'd0, '0, 64'h1111_2222_3333_BEEF, '0, 64'h4000, 2, "call");
        chk(got_pc_we && got_pc_val == 64'h4000 && !got_st_we, "R6 call redirect", got_pc_val, 64'h4000);
        chk(tmem[16'h0200] == 8'hBE && tmem[16'h01FF] == 8'hEF && sp == 16'h01FE, "R6 call stack",
            64'({tmem[16'h0200], tmem[16'h01FF], sp}), 64'hBEEF_01FE);
        run_req(OP_RET, 4'd0, '0, '0, '0, 64'h5555, 2, "ret");
        chk(got_pc_we && got_pc_val == 64'hBEEF, "R6 ret pc", got_pc_val, 64'hBEEF);
        chk(sp == 16'h0200, "R6 ret sp", 64'(sp), 64'h200);
        run_req(OP_LCALL, 4'd0, '0, 64'h1122_3344_5566_7788, '0, 64'h9000, 8, "lcall");
        chk(got_pc_we && got_pc_val == 64'h9000, "R7 lcall redirect", got_pc_val, 64'h9000);
        chk(tmem[16'h0200] == 8'h11 && tmem[16'h01F9] == 8'h88 && sp == 16'h01F8, "R7 lcall stack",
            64'({tmem[16'h0200], tmem[16'h01F9], sp}), 64'h1188_01F8);
        run_req(OP_LRET, 4'd0, '0, '0, '0, '0, 8, "lret");
        chk(got_pc_val == 64'h1122_3344_5566_7788 && sp == 16'h0200, "R7 lret pc", got_pc_val,
            64'h1122334455667788);
    endtask

    task automatic t_break();
        run_req(OP_BRK, 4'd0, '0, 64'hB0B1_B2B3_B4B5_B6B7, 64'hA0A1_A2A3_A4A5_A6A7, 64'hFFF0, 16, "brk");
        chk(got_pc_we && got_pc_val == 64'hFFF0 && !got_st_we, "R8 brk vector", got_pc_val, 64'hFFF0);
        chk(tmem[16'h0200] == 8'hA0 && tmem[16'h01F9] == 8'hA7, "R8 status first",
            64'({tmem[16'h0200], tmem[16'h01F9]}), 64'hA0A7);
        chk(tmem[16'h01F8] == 8'hB0 && tmem[16'h01F1] == 8'hB7 && sp == 16'h01F0, "R8 pc second",
            64'({tmem[16'h01F8], tmem[16'h01F1], sp}), 64'hB0B7_01F0);
    endtask

    task automatic t_rti();
        one_shot(OP_SETSP, 4'd0, 64'h0300);
        run_req(OP_PUSH, 4'd8, 64'hC0C1_C2C3_C4C5_C6C7, '0, '0, '0, 8, "rti pc frame");
        run_req(OP_PUSH, 4'd8, 64'hD0D1_D2D3_D4D5_D6D7, '0, '0, '0, 8, "rti status frame");
        run_req(OP_RTI, 4'd0, '0, '0, '0, 64'h1, 16, "rti");
        chk(got_st_we && got_st_val == 64'hD0D1_D2D3_D4D5_D6D7, "R9 status restored", got_st_val,
            64'hD0D1D2D3D4D5D6D7);
        chk(got_pc_we && got_pc_val == 64'hC0C1_C2C3_C4C5_C6C7, "R9 pc restored", got_pc_val,
            64'hC0C1C2C3C4C5C6C7);
        chk(sp == 16'h0300, "R9 sp", 64'(sp), 64'h300);
    endtask

    task automatic t_wrap();
        one_shot(OP_SETSP, 4'd0, 64'h0001);
        run_req(OP_PUSH, 4'd4, 64'h5566_7788, '0, '0, '0, 4, "wrap push");
        chk(sp == 16'hFFFD, "R11 wrap down", 64'(sp), 64'hFFFD);
        chk(tmem[16'h0000] == 8'h66 && tmem[16'hFFFF] == 8'h77 && tmem[16'hFFFE] == 8'h88,
            "R11 wrap bytes", 64'({tmem[16'h0000], tmem[16'hFFFF], tmem[16'hFFFE]}), 64'h667788);
        run_req(OP_PULL, 4'd4, '0, '0, '0, '0, 4, "wrap pull");
        chk(got_pull_data == 64'h5566_7788 && sp == 16'h0001, "R11 wrap up", got_pull_data, 64'h55667788);
    endtask

    initial begin
        for (int i = 0; i < 65536; i++) tmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_loads();
        t_push_pull();
        t_ignored();
        t_calls();
        t_break();
        t_rti();
        t_wrap();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule